// File: doc/BRIEF.md
# Shared-Address Double-Buffered Serial Data Port

This block is the data port of an asynchronous serial channel. Software reaches it through one bus address. A bus write to that address lands in a transmit holding register. A bus read from the same address returns a separate receive buffer. The transmit and receive data are kept in different storage, so a write can never be read back.

The transmit side places a parallel-in, serial-out shift register between the holding register and the serial output pin. The receive side places a serial-in, parallel-out shift register between the serial input pin and the receive buffer. Both directions are double-buffered. Software can queue the next byte to send while the current byte is still shifting out. A new character can also arrive while the previous one waits in the buffer.

A frame is one low start bit, eight data bits sent least-significant bit first, and one high stop bit. The line idles high. A one-cycle `bit_tick` pulse sets the transmit bit rate. A one-cycle `sample_tick` pulse at sixteen times that rate drives the receive oversampler. Four sticky flags report the block's condition: transmit-loaded, receive-full, overrun and framing error. Software clears them by writing to a second address, the status address.

Top module: `uart_dbuf_port`

State machines:
- Transmitter states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_STOP`.
  - IDLE→START on a bit tick when the holding register is full (a load).
  - START→DATA on the next bit tick.
  - DATA→STOP on the bit tick after the eighth data bit.
  - STOP→START on a bit tick when the holding register is full (a load with no gap).
  - STOP→IDLE on a bit tick when the holding register is empty.
- Receiver states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_STOP`.
  - IDLE→START when a low sample is seen.
  - START→IDLE at mid-bit if the line is high again (a glitch).
  - START→DATA at mid-bit if the line is still low.
  - DATA→STOP after the eighth data sample.
  - STOP→IDLE at the stop-bit sample. The frame is delivered or discarded at that point.

## Requirements
- R1: Address 0x99 is the data address. A write to it loads the transmit holding register. A read from it returns the receive buffer, never the written byte. The receive buffer resets to 0x00. A read from any other address returns 0x00.
- R2: The serial output idles high. Each frame is one low start bit, eight data bits sent LSB first, then one high stop bit. Each bit lasts one `bit_tick` period.
- R3: While a byte is shifting out, a write to 0x99 is held. When the holding register is full at the end of a stop bit, the next start bit begins on that same tick, with no idle bit between the frames.
- R4: `tx_loaded` goes to 1 when the holding register moves into the transmit shift register. This signals that a new write may be made.
- R5: A received frame with a high stop bit is stored in the receive buffer and sets `rx_full`. The receiver samples every bit at mid-bit with 16x oversampling.
- R6: The receive shift register captures a new frame while the previous byte is still unread. If software clears `rx_full` before the new frame ends, the new byte replaces the old one and `rx_full` is set again.
- R7: If a frame completes while `rx_full` is 1, the buffer keeps the old byte and `rx_overrun` is set.
- R8: A frame whose stop bit samples low is discarded. It sets `rx_frame_err` and leaves `rx_full` and the buffer unchanged.
- R9: A start bit that samples high again at mid-bit is treated as a glitch. The receiver returns to idle and no flag changes.
- R10: A write to the status address 0x98 clears flags by a 1 in a bit position. Bit 0 clears `tx_loaded`, bit 1 clears `rx_full`, bit 2 clears `rx_overrun` and bit 3 clears `rx_frame_err`. Flags whose bits are 0 are left as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bit_tick | input | 1 | One-cycle pulse per transmit bit time |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_loaded | output | 1 | Holding register transferred, free for a write |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_overrun | output | 1 | A frame arrived while the buffer was full |
| rx_frame_err | output | 1 | A frame ended with a low stop bit |

## Verification
The assertions assume that `bit_tick` and `sample_tick` are single-cycle pulses. They also assume that `rxd` holds each bit for a whole bit time, so each mid-bit sample sees a settled level.

The bench derives both ticks from one free-running counter: one sample tick every 4 clocks, and one bit tick every 64 clocks. It drives `rxd` only at the falling clock edge, in steps of 64 clocks. The one deliberate exception is the short glitch pulse, which is shorter than half a bit. Bus strobes last one clock each.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/uart_tx_path.sv
module uart_tx_path
    import uart_dbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              wr_load,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_flag,
    output logic              txd,
    output logic              loaded_flag
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

    tx_state_e         state, state_nx;
    logic [DATA_W-1:0] hold_q;
    logic              hold_full;
    logic [DATA_W-1:0] shift_q;
    logic [BW-1:0]     bit_cnt;
    logic              xfer;

    assign xfer = bit_tick && hold_full &&
                  (state == TX_IDLE || state == TX_STOP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (xfer) state_nx = TX_START;
            TX_START: if (bit_tick) state_nx = TX_DATA;
            TX_DATA:  if (bit_tick && bit_cnt == LAST) state_nx = TX_STOP;
            TX_STOP:  if (bit_tick) state_nx = hold_full ? TX_START : TX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd         <= 1'b1;
            hold_q      <= '0;
            hold_full   <= 1'b0;
            shift_q     <= '0;
            bit_cnt     <= '0;
            loaded_flag <= 1'b0;
        end else begin
            if (xfer) begin
                shift_q   <= hold_q;
                hold_full <= 1'b0;
                txd       <= 1'b0;
            end else if (bit_tick) begin
                unique case (state)
                    TX_START: begin
                        txd     <= shift_q[0];
                        shift_q <= shift_q >> 1;
                        bit_cnt <= '0;
                    end
                    TX_DATA: begin
                        if (bit_cnt == LAST) begin
                            txd <= 1'b1;
                        end else begin
                            txd     <= shift_q[0];
                            shift_q <= shift_q >> 1;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    TX_IDLE, TX_STOP: txd <= 1'b1;
                endcase
            end
            if (wr_load) begin
                hold_q    <= wr_data;
                hold_full <= 1'b1;
            end
            if (xfer)          loaded_flag <= 1'b1;
            else if (clr_flag) loaded_flag <= 1'b0;
        end
    end

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> txd);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |-> !txd);
    assert_flag_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> loaded_flag);
    assert_hold_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !xfer) |=> hold_full);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
    import uart_dbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rxd,
    input  logic              clr_full,
    input  logic              clr_ovr,
    input  logic              clr_ferr,
    output logic [DATA_W-1:0] buf_q,
    output logic              full_flag,
    output logic              ovr_flag,
    output logic              ferr_flag
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int OW = $clog2(OSR);
    localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);
    localparam logic [OW-1:0] MID  = OW'(OSR / 2 - 1);
    localparam logic [OW-1:0] FULL = OW'(OSR - 1);

    rx_state_e         state, state_nx;
    logic [1:0]        sync_q;
    logic              rx_s;
    logic [OW-1:0]     os_cnt;
    logic [BW-1:0]     bit_cnt;
    logic [DATA_W-1:0] shift_q;
    logic              stop_point;

    assign rx_s       = sync_q[1];
    assign stop_point = sample_tick && (state == RX_STOP) && (os_cnt == FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (sample_tick) begin
            unique case (state)
                RX_IDLE:  if (!rx_s) state_nx = RX_START;
                RX_START: if (os_cnt == MID) state_nx = rx_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (os_cnt == FULL && bit_cnt == LAST) state_nx = RX_STOP;
                RX_STOP:  if (os_cnt == FULL) state_nx = RX_IDLE;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_cnt    <= '0;
            bit_cnt   <= '0;
            shift_q   <= '0;
            buf_q     <= '0;
            full_flag <= 1'b0;
            ovr_flag  <= 1'b0;
            ferr_flag <= 1'b0;
        end else begin
            if (sample_tick) begin
                unique case (state)
                    RX_IDLE: os_cnt <= '0;
                    RX_START: begin
                        if (os_cnt == MID) begin
                            os_cnt  <= '0;
                            bit_cnt <= '0;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (os_cnt == FULL) begin
                            os_cnt  <= '0;
                            shift_q <= {rx_s, shift_q[DATA_W-1:1]};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                    RX_STOP: os_cnt <= (os_cnt == FULL) ? '0 : os_cnt + 1'b1;
                endcase
            end

            if (stop_point && rx_s && !full_flag) begin
                buf_q     <= shift_q;
                full_flag <= 1'b1;
            end else if (clr_full) begin
                full_flag <= 1'b0;
            end

            if (stop_point && rx_s && full_flag) ovr_flag <= 1'b1;
            else if (clr_ovr)                    ovr_flag <= 1'b0;

            if (stop_point && !rx_s) ferr_flag <= 1'b1;
            else if (clr_ferr)       ferr_flag <= 1'b0;
        end
    end

    assert_buf_kept_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_flag && !clr_full) |=> ($stable(buf_q) && full_flag));
    assert_ferr_not_delivered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr_flag) |-> !$rose(full_flag));
    assert_glitch_back_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && sample_tick && os_cnt == MID && rx_s) |=>
        (state == RX_IDLE && $stable(full_flag)));
    assert_one_flag_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({$rose(full_flag), $rose(ovr_flag), $rose(ferr_flag)}) <= 1);
endmodule

// File: rtl/uart_dbuf_port.sv
module uart_dbuf_port #(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 8,
    parameter int          OSR       = 16,
    parameter logic [7:0]  DATA_ADDR = 8'h99,
    parameter logic [7:0]  STAT_ADDR = 8'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bit_tick,
    input  logic              sample_tick,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_loaded,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              rx_frame_err
);
    logic              sel_data, sel_stat;
    logic              wr_data, wr_stat;
    logic [DATA_W-1:0] rx_buf;

    assign sel_data = (bus_addr == ADDR_W'(DATA_ADDR));
    assign sel_stat = (bus_addr == ADDR_W'(STAT_ADDR));
    assign wr_data  = bus_wr && sel_data;
    assign wr_stat  = bus_wr && sel_stat;
    assign bus_rdata = (bus_rd && sel_data) ? rx_buf : '0;

    uart_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_tick    (bit_tick),
        .wr_load     (wr_data),
        .wr_data     (bus_wdata),
        .clr_flag    (wr_stat && bus_wdata[0]),
        .txd         (txd),
        .loaded_flag (tx_loaded)
    );

    uart_rx_path #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rxd         (rxd),
        .clr_full    (wr_stat && bus_wdata[1]),
        .clr_ovr     (wr_stat && bus_wdata[2]),
        .clr_ferr    (wr_stat && bus_wdata[3]),
        .buf_q       (rx_buf),
        .full_flag   (rx_full),
        .ovr_flag    (rx_overrun),
        .ferr_flag   (rx_frame_err)
    );

    assert_read_other_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !sel_data) |-> (bus_rdata == '0));
    assert_status_write_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bit_tick && !tx_loaded) |=> !tx_loaded);
endmodule

// File: tb/test_uart_dbuf_port.sv
module test_uart_dbuf_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bit_tick = 1'b0, sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, tx_loaded, rx_full, rx_overrun, rx_frame_err;

    int n_chk = 0, n_fail = 0, b2b_cnt = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    uart_dbuf_port i_uart_dbuf_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bit_tick(bit_tick), .sample_tick(sample_tick), .rxd(rxd), .txd(txd),
        .tx_loaded(tx_loaded), .rx_full(rx_full), .rx_overrun(rx_overrun),
        .rx_frame_err(rx_frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // tick generator: sample every 4 clocks, bit every 64 clocks
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt + 1) % 64;
            sample_tick = (cnt % 4 == 0);
            bit_tick    = (cnt == 0);
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: transmit a byte and record the expectation
    task automatic tx_send(input logic [7:0] d);
        tx_q.push_back(d);
        bus_write(8'h99, d);
    endtask

    // driver: put a frame on rxd; stop_low_len > 0 gives a bad stop bit
    task automatic rx_frame(input logic [7:0] d, input int stop_low_len);
        @(negedge clk);
        rxd = 1'b0; clks(64);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; clks(64);
        end
        if (stop_low_len > 0) begin
            rxd = 1'b0; clks(stop_low_len);
        end
        rxd = 1'b1; clks(64);
    endtask

    task automatic rx_expect_read(input string req);
        logic [7:0] got, exp;
        bus_read(8'h99, got);
        exp = (rx_q.size() > 0) ? rx_q.pop_front() : 8'hxx;
        check(got === exp, req, got, exp);
    endtask

    // monitor: decode transmitted frames and compare to the scoreboard
    initial begin
        logic [7:0] got;
        bit cont;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (txd === 1'b0) begin
                clks(31);
                cont = 1'b1;
                while (cont) begin
                    check(txd === 1'b0, "R2 start bit", txd, 0);
                    for (int i = 0; i < 8; i++) begin
                        clks(64);
                        got[i] = txd;
                    end
                    clks(64);
                    check(txd === 1'b1, "R2 stop bit", txd, 1);
                    if (tx_q.size() == 0) check(0, "R2 unexpected frame", got, 0);
                    else begin
                        logic [7:0] e;
                        e = tx_q.pop_front();
                        check(got === e, "R2 frame data", got, e);
                    end
                    clks(64);
                    if (txd === 1'b0) b2b_cnt++;
                    else cont = 1'b0;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        clks(5);
        check(txd === 1'b1, "R2 idle high at reset", txd, 1);
        check({tx_loaded, rx_full, rx_overrun, rx_frame_err} === 4'b0,
              "R10 flags clear at reset",
              {tx_loaded, rx_full, rx_overrun, rx_frame_err}, 0);
        rst_n = 1'b1;
        clks(5);

        // R1: write then read the same address returns the receive buffer
        tx_send(8'hA5);
        bus_read(8'h99, rd);
        check(rd === 8'h00, "R1 read returns rx buffer not written byte", rd, 0);
        bus_read(8'h42, rd);
        check(rd === 8'h00, "R1 other address reads zero", rd, 0);

        // R4: flag on transfer into shift register
        clks(70);
        check(tx_loaded === 1'b1, "R4 loaded flag after transfer", tx_loaded, 1);
        bus_write(8'h98, 8'h01);
        check(tx_loaded === 1'b0, "R10 clear loaded flag", tx_loaded, 0);

        // R3: queue next byte while shifting; no gap
        tx_send(8'h3C);
        clks(30);
        check(tx_loaded === 1'b0, "R3 held byte waits for stop", tx_loaded, 0);
        clks(1400);
        check(b2b_cnt == 1, "R3 back-to-back frames", b2b_cnt, 1);
        check(tx_q.size() == 0, "R2 all frames sent", tx_q.size(), 0);
        check(tx_loaded === 1'b1, "R4 flag set by second transfer", tx_loaded, 1);
        check(txd === 1'b1, "R2 idle high after frames", txd, 1);

        // single frame with a different pattern, no back-to-back
        bus_write(8'h98, 8'h01);
        tx_send(8'h81);
        clks(800);
        check(b2b_cnt == 1, "R3 lone frame has idle after", b2b_cnt, 1);

        // R5: basic reception
        rx_q.push_back(8'h5A);
        rx_frame(8'h5A, 0);
        check(rx_full === 1'b1, "R5 rx_full set", rx_full, 1);
        check({rx_overrun, rx_frame_err} === 2'b00, "R5 no error flags",
              {rx_overrun, rx_frame_err}, 0);
        rx_expect_read("R5 received byte");
        bus_write(8'h98, 8'h02);
        check(rx_full === 1'b0, "R10 clear rx_full", rx_full, 0);

        // R6: overlap reception with service
        rx_q.push_back(8'hC3);
        rx_frame(8'hC3, 0);
        rx_q.push_back(8'h96);
        fork
            rx_frame(8'h96, 0);
            begin
                clks(200);
                rx_expect_read("R6 old byte readable during next frame");
                bus_write(8'h98, 8'h02);
            end
        join
        check(rx_full === 1'b1, "R6 second byte delivered", rx_full, 1);
        rx_expect_read("R6 second byte");
        bus_write(8'h98, 8'h02);

        // R7: overrun keeps the old byte
        rx_q.push_back(8'h11);
        rx_frame(8'h11, 0);
        rx_frame(8'h22, 0);
        check(rx_overrun === 1'b1, "R7 overrun set", rx_overrun, 1);
        rx_expect_read("R7 buffer keeps old byte");
        bus_write(8'h98, 8'h04);
        check(rx_overrun === 1'b0 && rx_full === 1'b1,
              "R10 clear overrun only", {rx_overrun, rx_full}, 2'b01);
        bus_write(8'h98, 8'h02);
        check(rx_full === 1'b0, "R10 clear rx_full", rx_full, 0);

        // R8: framing error discards frame
        rx_frame(8'h77, 48);
        check(rx_frame_err === 1'b1, "R8 framing error set", rx_frame_err, 1);
        check(rx_full === 1'b0, "R8 frame not delivered", rx_full, 0);
        bus_read(8'h99, rd);
        check(rd === 8'h11, "R8 buffer unchanged", rd, 8'h11);
        bus_write(8'h98, 8'h08);
        check(rx_frame_err === 1'b0, "R10 clear framing error", rx_frame_err, 0);

        // R9: start glitch ignored, then a good frame
        @(negedge clk);
        rxd = 1'b0; clks(16);
        rxd = 1'b1; clks(200);
        check({rx_full, rx_overrun, rx_frame_err} === 3'b000,
              "R9 glitch changes no flag", {rx_full, rx_overrun, rx_frame_err}, 0);
        rx_q.push_back(8'hE7);
        rx_frame(8'hE7, 0);
        check(rx_full === 1'b1, "R9 receiver recovered", rx_full, 1);
        rx_expect_read("R9 byte after glitch");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule